// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vectoring Logic

This block holds the interrupt state of a two-channel serial controller. Each channel keeps four flags: receive pending, transmit pending, receive under service and transmit under service. From these flags the block builds a shared six-bit pending register and a modified interrupt vector. It also drives a single interrupt line, which is the OR of the request conditions of both channels. The UART datapath, the baud generator and the register front end sit outside this block.

The front end gives the block the following inputs:
- single-cycle event strobes for each channel: byte received, transmit buffer emptied, break detected, data register read and data register written;
- the three-bit command field of each channel, with a write strobe;
- the interrupt enable fields;
- the status-high mode bit, which is shared by both channels.

Channel A is index 1 of every two-bit port. Channel B is index 0. Receive service takes precedence over transmit service, and the vector holds the most recent vector-changing action.

Top module: `serial_irq_vec`

## Requirements
- R1: `irq_o` is 1 exactly when at least one channel meets one of these conditions: its transmit enable is set and transmit is pending; its two-bit receive mode is 01 or 10 and receive is pending; its break enable is set and its break status is set. `irq_o` follows the enable inputs within the same cycle.
- R2: A received-byte strobe has these effects on that channel one cycle later:
  - it sets receive available, receive pending, receive under service and the receive pending bit;
  - it loads the receive vector code of that channel.
  When both channels write the vector in the same cycle, channel A wins.
- R3: A transmit-emptied strobe has these effects one cycle later:
  - it sets transmit empty, all sent and transmit pending;
  - only if receive is not under service, it sets transmit under service and loads the transmit vector code;
  - in that case it also sets the transmit pending bit, but only if transmit interrupts are enabled.
- R4: `pend_o` has this layout: bit0 external B, bit1 transmit B, bit2 receive B, bit3 external A, bit4 transmit A, bit5 receive A. The external bits read 0.
- R5: With `stat_hi_i`=0, the vector reads as follows: no interrupt 0x06, receive A 0x0C, receive B 0x04, transmit A 0x08, transmit B 0x00.
- R6: With `stat_hi_i`=1, the vector reads as follows: no interrupt 0x60, receive A 0x30, receive B 0x20, transmit A 0x10, transmit B 0x00. The code follows the current mode bit.
- R7: Command 101 does the following:
  - it clears transmit pending, transmit under service and the transmit pending bit;
  - it loads the no-interrupt vector;
  - if receive is still pending, it asserts the receive interrupt state again.
- R8: Command 111 behaves as follows:
  - if receive is under service, it clears receive under service and then services a pending transmit;
  - otherwise it clears transmit under service.
- R9: A data read does the following:
  - it clears receive available, receive pending, receive under service and the receive pending bit;
  - it loads the no-interrupt vector;
  - if transmit is pending, it services transmit instead.
- R10: A data write clears transmit pending, transmit empty and all sent. It leaves the pending register and the vector unchanged.
- R11: Reset has these effects:
  - it clears every flag, the pending register, receive available, all sent and break status;
  - it sets transmit empty;
  - the vector reads the no-interrupt code of the current mode.
- R12: When an event strobe and a clearing action reach the same channel in the same cycle, the event wins.
- R13: A break strobe sets the break status of that channel. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_byte_i | input | 2 | Byte received strobe per channel |
| tx_done_i | input | 2 | Transmit buffer emptied strobe per channel |
| brk_det_i | input | 2 | Break detected strobe per channel |
| rd_data_i | input | 2 | Data register read strobe per channel |
| wr_data_i | input | 2 | Data register write strobe per channel |
| cmd_wr_i | input | 2 | Command field write strobe per channel |
| cmd_i | input | 6 | Command field per channel, [5:3] A, [2:0] B |
| tx_ie_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode per channel, [3:2] A, [1:0] B |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| stat_hi_i | input | 1 | Status-high vector mode |
| irq_o | output | 1 | Combined interrupt request |
| vec_o | output | 8 | Modified interrupt vector |
| pend_o | output | 6 | Shared pending register |
| rx_avail_o | output | 2 | Receive character available per channel |
| tx_empty_o | output | 2 | Transmit buffer empty per channel |
| all_sent_o | output | 2 | All sent per channel |
| brk_o | output | 2 | Break status per channel |

## Verification
An under-service flag that is stuck or set wrongly stays hidden until a later event. For example, a stale receive-under-service flag only shows as a missing transmit vector on the next transmit-emptied strobe, or on the next command 111. For that reason the sequences interleave receive, transmit and service commands on the same channel, and check `vec_o` and `pend_o` one cycle after every strobe. A wrong pending flag shows up on `irq_o` in the cycle after the strobe. A stale pending-register bit shows up on `pend_o` even while `irq_o` is low.

// File: rtl/serial_irq_pkg.sv
package serial_irq_pkg;
  localparam int NCH    = 2;
  localparam int CMD_W  = 3;
  localparam int MODE_W = 2;
  localparam int VEC_W  = 8;
  localparam int PEND_W = 3 * NCH;

  localparam logic [CMD_W-1:0] CMD_CLR_TX  = 3'b101;
  localparam logic [CMD_W-1:0] CMD_RST_IUS = 3'b111;

  typedef enum logic [1:0] {LK_NONE, LK_RX, LK_TX} loc_kind_e;
  typedef enum logic [2:0] {VK_NONE, VK_RXA, VK_RXB, VK_TXA, VK_TXB} vec_kind_e;

  function automatic logic [VEC_W-1:0] vec_code(vec_kind_e k, logic hi);
    case (k)
      VK_RXA:  return hi ? 8'h30 : 8'h0C;
      VK_RXB:  return hi ? 8'h20 : 8'h04;
      VK_TXA:  return hi ? 8'h10 : 8'h08;
      VK_TXB:  return 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction
endpackage

// File: rtl/sirq_cmd_dec.sv
module sirq_cmd_dec
  import serial_irq_pkg::*;
(
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             clr_tx_o,
  output logic             rst_ius_o
);
  assign clr_tx_o  = cmd_wr_i && (cmd_i == CMD_CLR_TX);
  assign rst_ius_o = cmd_wr_i && (cmd_i == CMD_RST_IUS);
endmodule

// File: rtl/sirq_chan.sv
module sirq_chan
  import serial_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_byte_i,
  input  logic              tx_done_i,
  input  logic              brk_det_i,
  input  logic              rd_data_i,
  input  logic              wr_data_i,
  input  logic              clr_tx_i,
  input  logic              rst_ius_i,
  input  logic              tx_ie_i,
  input  logic [MODE_W-1:0] rx_mode_i,
  input  logic              brk_ie_i,
  output logic              irq_req_o,
  output logic              pend_rx_o,
  output logic              pend_tx_o,
  output logic              vec_we_o,
  output loc_kind_e         vec_kind_o,
  output logic              rx_avail_o,
  output logic              tx_empty_o,
  output logic              all_sent_o,
  output logic              brk_o
);
  logic rxp_q, txp_q, rxs_q, txs_q, prx_q, ptx_q;
  logic n_rxp, n_txp, n_rxs, n_txs, n_prx, n_ptx;
  logic avail_q, empty_q, sent_q, brk_q;
  logic we;
  loc_kind_e kind;

  // clearing actions first, events after so they win (R12)
  always_comb begin
    n_rxp = rxp_q; n_txp = txp_q; n_rxs = rxs_q;
    n_txs = txs_q; n_prx = prx_q; n_ptx = ptx_q;
    we    = 1'b0;
    kind  = LK_NONE;
    if (rd_data_i) begin
      n_rxp = 1'b0; n_rxs = 1'b0; n_prx = 1'b0;
      we = 1'b1; kind = LK_NONE;
      if (n_txp) begin
        n_txs = 1'b1;
        if (tx_ie_i) n_ptx = 1'b1;
        kind = LK_TX;
      end
    end else if (wr_data_i) begin
      n_txp = 1'b0;
    end else if (clr_tx_i) begin
      n_txp = 1'b0; n_txs = 1'b0; n_ptx = 1'b0;
      we = 1'b1; kind = LK_NONE;
      if (n_rxp) begin
        n_rxs = 1'b1; n_prx = 1'b1; kind = LK_RX;
      end
    end else if (rst_ius_i) begin
      if (n_rxs) begin
        n_rxs = 1'b0;
        if (n_txp) begin
          n_txs = 1'b1;
          if (tx_ie_i) n_ptx = 1'b1;
          we = 1'b1; kind = LK_TX;
        end
      end else if (n_txs) begin
        n_txs = 1'b0;
      end
    end
    if (rx_byte_i) begin
      n_rxp = 1'b1; n_rxs = 1'b1; n_prx = 1'b1;
      we = 1'b1; kind = LK_RX;
    end
    if (tx_done_i) begin
      n_txp = 1'b1;
      if (!n_rxs) begin
        n_txs = 1'b1;
        if (tx_ie_i) n_ptx = 1'b1;
        we = 1'b1; kind = LK_TX;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxp_q <= 1'b0; txp_q <= 1'b0; rxs_q <= 1'b0;
      txs_q <= 1'b0; prx_q <= 1'b0; ptx_q <= 1'b0;
    end else begin
      rxp_q <= n_rxp; txp_q <= n_txp; rxs_q <= n_rxs;
      txs_q <= n_txs; prx_q <= n_prx; ptx_q <= n_ptx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avail_q <= 1'b0;
      empty_q <= 1'b1;
      sent_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      if (rx_byte_i)      avail_q <= 1'b1;
      else if (rd_data_i) avail_q <= 1'b0;
      if (tx_done_i) begin
        empty_q <= 1'b1;
        sent_q  <= 1'b1;
      end else if (wr_data_i) begin
        empty_q <= 1'b0;
        sent_q  <= 1'b0;
      end
      if (brk_det_i) brk_q <= 1'b1;
    end
  end

  logic rx_mode_on;
  assign rx_mode_on = (rx_mode_i == 2'b01) || (rx_mode_i == 2'b10);
  assign irq_req_o  = (tx_ie_i && txp_q) || (rx_mode_on && rxp_q) || (brk_ie_i && brk_q);
  assign pend_rx_o  = prx_q;
  assign pend_tx_o  = ptx_q;
  assign vec_we_o   = we;
  assign vec_kind_o = kind;
  assign rx_avail_o = avail_q;
  assign tx_empty_o = empty_q;
  assign all_sent_o = sent_q;
  assign brk_o      = brk_q;
endmodule

// File: rtl/sirq_vec_sel.sv
module sirq_vec_sel
  import serial_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_a_i,
  input  loc_kind_e        kind_a_i,
  input  logic             we_b_i,
  input  loc_kind_e        kind_b_i,
  input  logic             stat_hi_i,
  output logic [VEC_W-1:0] vec_o
);
  vec_kind_e vk_q, vk_d;

  always_comb begin
    vk_d = vk_q;
    if (we_a_i) begin
      case (kind_a_i)
        LK_RX:   vk_d = VK_RXA;
        LK_TX:   vk_d = VK_TXA;
        default: vk_d = VK_NONE;
      endcase
    end else if (we_b_i) begin
      case (kind_b_i)
        LK_RX:   vk_d = VK_RXB;
        LK_TX:   vk_d = VK_TXB;
        default: vk_d = VK_NONE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vk_q <= VK_NONE;
    else         vk_q <= vk_d;
  end

  // encoded with the mode in force now, not when stored
  assign vec_o = vec_code(vk_q, stat_hi_i);
endmodule

// File: rtl/serial_irq_vec.sv
module serial_irq_vec
  import serial_irq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NCH-1:0]        rx_byte_i,
  input  logic [NCH-1:0]        tx_done_i,
  input  logic [NCH-1:0]        brk_det_i,
  input  logic [NCH-1:0]        rd_data_i,
  input  logic [NCH-1:0]        wr_data_i,
  input  logic [NCH-1:0]        cmd_wr_i,
  input  logic [NCH*CMD_W-1:0]  cmd_i,
  input  logic [NCH-1:0]        tx_ie_i,
  input  logic [NCH*MODE_W-1:0] rx_mode_i,
  input  logic [NCH-1:0]        brk_ie_i,
  input  logic                  stat_hi_i,
  output logic                  irq_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [PEND_W-1:0]     pend_o,
  output logic [NCH-1:0]        rx_avail_o,
  output logic [NCH-1:0]        tx_empty_o,
  output logic [NCH-1:0]        all_sent_o,
  output logic [NCH-1:0]        brk_o
);
  logic [NCH-1:0] clr_tx, rst_ius, req, prx, ptx, vwe;
  loc_kind_e      vkind [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sirq_cmd_dec u_dec (
      .cmd_wr_i  (cmd_wr_i[c]),
      .cmd_i     (cmd_i[c*CMD_W +: CMD_W]),
      .clr_tx_o  (clr_tx[c]),
      .rst_ius_o (rst_ius[c])
    );

    sirq_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rx_byte_i  (rx_byte_i[c]),
      .tx_done_i  (tx_done_i[c]),
      .brk_det_i  (brk_det_i[c]),
      .rd_data_i  (rd_data_i[c]),
      .wr_data_i  (wr_data_i[c]),
      .clr_tx_i   (clr_tx[c]),
      .rst_ius_i  (rst_ius[c]),
      .tx_ie_i    (tx_ie_i[c]),
      .rx_mode_i  (rx_mode_i[c*MODE_W +: MODE_W]),
      .brk_ie_i   (brk_ie_i[c]),
      .irq_req_o  (req[c]),
      .pend_rx_o  (prx[c]),
      .pend_tx_o  (ptx[c]),
      .vec_we_o   (vwe[c]),
      .vec_kind_o (vkind[c]),
      .rx_avail_o (rx_avail_o[c]),
      .tx_empty_o (tx_empty_o[c]),
      .all_sent_o (all_sent_o[c]),
      .brk_o      (brk_o[c])
    );

    // per channel: ext, tx, rx from low to high
    assign pend_o[3*c]     = 1'b0;
    assign pend_o[3*c + 1] = ptx[c];
    assign pend_o[3*c + 2] = prx[c];
  end

  sirq_vec_sel u_vsel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_a_i    (vwe[1]),
    .kind_a_i  (vkind[1]),
    .we_b_i    (vwe[0]),
    .kind_b_i  (vkind[0]),
    .stat_hi_i (stat_hi_i),
    .vec_o     (vec_o)
  );

  assign irq_o = |req;
endmodule

// File: rtl/serial_irq_vec_chk.sv
module serial_irq_vec_chk
  import serial_irq_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NCH-1:0]        rx_byte_i,
  input logic [NCH-1:0]        tx_done_i,
  input logic [NCH-1:0]        brk_det_i,
  input logic [NCH-1:0]        rd_data_i,
  input logic [NCH-1:0]        wr_data_i,
  input logic [NCH-1:0]        cmd_wr_i,
  input logic [NCH*CMD_W-1:0]  cmd_i,
  input logic [NCH-1:0]        tx_ie_i,
  input logic [NCH*MODE_W-1:0] rx_mode_i,
  input logic [NCH-1:0]        brk_ie_i,
  input logic                  stat_hi_i,
  input logic                  irq_o,
  input logic [VEC_W-1:0]      vec_o,
  input logic [PEND_W-1:0]     pend_o,
  input logic [NCH-1:0]        rx_avail_o,
  input logic [NCH-1:0]        tx_empty_o,
  input logic [NCH-1:0]        all_sent_o,
  input logic [NCH-1:0]        brk_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ast
    AST_RX_AVAIL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rx_byte_i[c] |=> rx_avail_o[c]); // R2
    AST_RD_CLEARS_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_i[c] && !rx_byte_i[c] |=> !rx_avail_o[c]); // R9
    AST_WR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_data_i[c] && !tx_done_i[c] |=> !tx_empty_o[c] && !all_sent_o[c]); // R10
    AST_DONE_SETS_SENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_done_i[c] |=> tx_empty_o[c] && all_sent_o[c]); // R3
    AST_BRK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_o[c] |=> brk_o[c]); // R13
    AST_BRK_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      brk_o[c] && brk_ie_i[c] |-> irq_o); // R1
  end

  AST_RXA_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_byte_i[1] |=> vec_o == (stat_hi_i ? 8'h30 : 8'h0C)); // R2
endmodule

bind serial_irq_vec serial_irq_vec_chk u_chk (.*);

// File: tb/serial_irq_vec_bench.sv
module serial_irq_vec_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] rx_byte_i = '0, tx_done_i = '0, brk_det_i = '0;
  logic [1:0] rd_data_i = '0, wr_data_i = '0, cmd_wr_i = '0;
  logic [5:0] cmd_i = '0;
  logic [1:0] tx_ie_i = 2'b11;
  logic [3:0] rx_mode_i = 4'b0101;
  logic [1:0] brk_ie_i = 2'b00;
  logic       stat_hi_i = 1'b0;
  logic       irq_o;
  logic [7:0] vec_o;
  logic [5:0] pend_o;
  logic [1:0] rx_avail_o, tx_empty_o, all_sent_o, brk_o;

  int n_chk = 0;
  int n_fail = 0;

  serial_irq_vec u_serial_irq_vec (.*);

  always #10 clk_i = ~clk_i;

  // row: {stat_hi, ch(1=A), op, irq, vec, pend}
  // op: 0 idle, 1 rx byte, 2 tx emptied, 3 read, 4 write, 5 cmd 101, 6 cmd 111
  localparam int NROW = 19;
  localparam logic [19:0] TBL [NROW] = '{
    {1'b0, 1'b0, 3'd1, 1'b1, 8'h04, 6'h04},  // R2 rx B
    {1'b0, 1'b0, 3'd2, 1'b1, 8'h04, 6'h04},  // R3 tx B blocked by rx service
    {1'b0, 1'b0, 3'd3, 1'b1, 8'h00, 6'h02},  // R9 read hands over to tx
    {1'b0, 1'b0, 3'd5, 1'b0, 8'h06, 6'h00},  // R7
    {1'b0, 1'b1, 3'd2, 1'b1, 8'h08, 6'h10},  // R3 tx A serviced
    {1'b0, 1'b1, 3'd1, 1'b1, 8'h0C, 6'h30},  // R2 R4
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h08, 6'h30},  // R8 release rx, service tx
    {1'b0, 1'b1, 3'd6, 1'b1, 8'h08, 6'h30},  // R8 release tx
    {1'b0, 1'b1, 3'd4, 1'b1, 8'h08, 6'h30},  // R10
    {1'b0, 1'b1, 3'd3, 1'b0, 8'h06, 6'h10},  // R9 no tx pending
    {1'b0, 1'b1, 3'd5, 1'b0, 8'h06, 6'h00},  // R7
    {1'b1, 1'b0, 3'd0, 1'b0, 8'h60, 6'h00},  // R6
    {1'b1, 1'b1, 3'd1, 1'b1, 8'h30, 6'h20},  // R6
    {1'b1, 1'b0, 3'd1, 1'b1, 8'h20, 6'h24},  // R6
    {1'b1, 1'b0, 3'd2, 1'b1, 8'h20, 6'h24},  // R3
    {1'b1, 1'b0, 3'd3, 1'b1, 8'h00, 6'h22},  // R9 R6
    {1'b0, 1'b0, 3'd0, 1'b1, 8'h00, 6'h22},  // R5
    {1'b0, 1'b1, 3'd3, 1'b1, 8'h06, 6'h02},  // R9 R1
    {1'b0, 1'b0, 3'd5, 1'b0, 8'h06, 6'h00}   // R7
  };

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // drive strobes for one cycle; returns at the next falling edge
  task automatic pulse(input logic [1:0] rxb, input logic [1:0] txd, input logic [1:0] brk,
                       input logic [1:0] rd, input logic [1:0] wr, input logic [1:0] cw,
                       input logic [5:0] cmd);
    rx_byte_i = rxb; tx_done_i = txd; brk_det_i = brk;
    rd_data_i = rd;  wr_data_i = wr;  cmd_wr_i = cw; cmd_i = cmd;
    @(negedge clk_i);
    rx_byte_i = '0; tx_done_i = '0; brk_det_i = '0;
    rd_data_i = '0; wr_data_i = '0; cmd_wr_i = '0; cmd_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic check_reset(input string tag);
    check("R11", {tag, " irq"}, irq_o, 1'b0);
    check("R11", {tag, " vec"}, vec_o, 8'h06);
    check("R11", {tag, " pend"}, pend_o, 6'h00);
    check("R11", {tag, " rx_avail"}, rx_avail_o, 2'b00);
    check("R11", {tag, " tx_empty"}, tx_empty_o, 2'b11);
    check("R11", {tag, " all_sent"}, all_sent_o, 2'b00);
    check("R11", {tag, " brk"}, brk_o, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    check_reset("initial");

    for (int i = 0; i < NROW; i++) begin
      logic [1:0] m;
      logic [2:0] op;
      m  = TBL[i][18] ? 2'b10 : 2'b01;
      op = TBL[i][17:15];
      stat_hi_i = TBL[i][19];
      pulse((op == 3'd1) ? m : 2'b00, (op == 3'd2) ? m : 2'b00, 2'b00,
            (op == 3'd3) ? m : 2'b00, (op == 3'd4) ? m : 2'b00,
            (op == 3'd5 || op == 3'd6) ? m : 2'b00,
            (op == 3'd5) ? 6'b101101 : ((op == 3'd6) ? 6'b111111 : 6'b000000));
      check("R1", $sformatf("row %0d irq", i), irq_o, TBL[i][14]);
      check("R5/R6", $sformatf("row %0d vec", i), vec_o, TBL[i][13:6]);
      check("R4", $sformatf("row %0d pend", i), pend_o, TBL[i][5:0]);
    end

    stat_hi_i = 1'b0;
    do_reset();
    check_reset("second");

    // R10 write clears empty and all sent
    pulse(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 6'h00);
    check("R10", "tx_empty after write A", tx_empty_o, 2'b01);
    check("R10", "all_sent after write A", all_sent_o, 2'b00);
    // R3 emptied strobe
    pulse(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 6'h00);
    check("R3", "tx_empty after done A", tx_empty_o, 2'b11);
    check("R3", "all_sent after done A", all_sent_o, 2'b10);
    check("R3", "vec after done A", vec_o, 8'h08);
    check("R3", "irq after done A", irq_o, 1'b1);
    // R12 write and emptied on B together
    pulse(2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 6'h00);
    check("R12", "tx_empty wr+done B", tx_empty_o, 2'b11);
    check("R12", "all_sent wr+done B", all_sent_o, 2'b11);
    check("R12", "vec wr+done B", vec_o, 8'h00);
    // R1 enable masking within the cycle
    tx_ie_i = 2'b00;
    #1;
    check("R1", "irq with tx enables off", irq_o, 1'b0);
    tx_ie_i = 2'b11;
    #1;
    check("R1", "irq with tx enables on", irq_o, 1'b1);
    // R7 on both channels
    pulse(2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 6'b101101);
    check("R7", "vec after clear both", vec_o, 8'h06);
    check("R7", "irq after clear both", irq_o, 1'b0);
    // R12 read and received byte together on A
    pulse(2'b10, 2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 6'h00);
    check("R12", "rx_avail rd+rx A", rx_avail_o, 2'b10);
    check("R12", "irq rd+rx A", irq_o, 1'b1);
    check("R12", "vec rd+rx A", vec_o, 8'h0C);
    rx_mode_i = 4'b1101;
    #1;
    check("R1", "irq rx mode 11", irq_o, 1'b0);
    rx_mode_i = 4'b1001;
    #1;
    check("R1", "irq rx mode 10", irq_o, 1'b1);
    rx_mode_i = 4'b0101;
    // R2 channel A wins the vector
    pulse(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 6'h00);
    check("R2", "vec rx both", vec_o, 8'h0C);
    check("R2", "rx_avail rx both", rx_avail_o, 2'b11);
    check("R4", "pend rx both", pend_o, 6'h24);

    do_reset();
    check_reset("third");
    // R13 break
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 6'h00);
    check("R13", "brk after det B", brk_o, 2'b01);
    check("R1", "irq brk disabled", irq_o, 1'b0);
    brk_ie_i = 2'b01;
    #1;
    check("R13", "irq brk enabled", irq_o, 1'b1);
    pulse(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 6'h00);
    check("R13", "brk after read B", brk_o, 2'b01);
    check("R13", "irq after read B", irq_o, 1'b1);
    brk_ie_i = 2'b00;
    do_reset();
    check("R11", "brk after reset", brk_o, 2'b00);

    finish_run();
  end
endmodule